// File: doc/BRIEF.md
# Color Lookup Table Controller

This block owns the color table of one picture layer: up to 256 entries of 32 bits that a pixel format converter indexes with an 8-bit value. Three users reach the table. The converter issues lookups on a dedicated port and gets the entry one cycle later. The CPU reads and writes entries through a word-addressed register port, where the table occupies the window starting at byte offset 0x400. A built-in loader copies a table from system memory on its own, through a read port with a request/grant handshake.

Software sets up an automatic load in three steps. It writes the start address register, writes the entry count minus one into the size field of the control register, and sets the start bit in the same control write. The loader fetches 32-bit words with one read in flight at a time. In 32-bit format it takes one entry per word. In 24-bit format it unpacks three-byte entries that run across word boundaries. The start bit reads back as 1 until the last entry is stored, and a one-cycle completion pulse follows. While the load runs, the CPU cannot reach the table. A colliding access is dropped, and it sets a sticky error flag that raises the interrupt only when its enable bit is set.

Top module: `clut_ctrl`

## Requirements
- R1: After reset the control, start address and status registers read 0, `irq` is low and `mrd_req` is low.
- R2: With no load running, a CPU write to byte offset 0x400 + 4*i stores the 32-bit word in entry i. A read of that offset returns the entry on `cpu_rdata`, with `cpu_rvalid` high, one cycle after `cpu_re`.
- R3: A converter lookup with `lk_req` high returns entry `lk_idx` on `lk_data`, with `lk_valid` high, in the following cycle.
- R4: The control register sits at offset 0x000, with start in bit 0, 32-bit format in bit 1, size in bits 15:8 and interrupt enable in bit 16. The start address register sits at offset 0x004. A control write with bit 0 set, made while idle, starts a load of size+1 entries into entries 0 through size. Bit 0 reads back 1 while the load runs.
- R5: In 32-bit format, entry i is the word at start address + 4*i.
- R6: In 24-bit format, entry i takes stream bytes 3i, 3i+1 and 3i+2 into bits 7:0, 15:8 and 23:16, with bits 31:24 set to 0xFF. Stream byte k is byte k mod 4 (little-endian) of the word at start address + 4*(k div 4).
- R7: The loader keeps one read in flight. It holds `mrd_req` and `mrd_addr` until granted, then issues word addresses from the start address upward in steps of 4. A load reads exactly ceil(bytes/4) words, where bytes is 4 or 3 times the entry count.
- R8: When the last entry is stored, the start bit clears and `load_done` pulses high for exactly one cycle.
- R9: During a load, a CPU write to the table window is dropped and leaves the entry unchanged. A CPU read of the window returns 0, with `cpu_rvalid` high.
- R10: A table access during a load sets status bit 0 (offset 0x008). The bit stays set until software writes 1 to it.
- R11: `irq` is high exactly when status bit 0 and the interrupt enable bit are both set.
- R12: Writes to the control and start address registers made during a load are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_addr | input | 12 | CPU byte offset |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after `cpu_re` |
| irq | output | 1 | Access-error interrupt |
| lk_req | input | 1 | Converter lookup request |
| lk_idx | input | 8 | Converter lookup index |
| lk_data | output | 32 | Looked-up entry |
| lk_valid | output | 1 | Lookup result valid |
| mrd_req | output | 1 | Memory read request |
| mrd_addr | output | 32 | Memory read word address |
| mrd_gnt | input | 1 | Memory read grant |
| mrd_rvalid | input | 1 | Memory read data valid |
| mrd_rdata | input | 32 | Memory read data |
| load_done | output | 1 | One-cycle pulse when a load finishes |

## Verification
The assertions assume that the memory side never returns `mrd_rvalid` without a granted read, and never in the same cycle as the grant. They also assume the CPU never raises `cpu_we` and `cpu_re` together, and that start addresses are word aligned. The bench's memory responder grants requests after a random delay and returns data only for the read it granted, one or more cycles later. The CPU stimulus issues one aligned strobe at a time. This keeps every run within those limits while the grant and data latencies vary, so the 24-bit unpacking sees bytes carried over from earlier words at different timings.

// File: rtl/clut_pkg.sv
package clut_pkg;

  localparam int CTRL_OFS = 'h000;
  localparam int ADDR_OFS = 'h004;
  localparam int STAT_OFS = 'h008;

  // bytes that one table entry occupies in memory
  function automatic logic [2:0] entry_bytes(input logic fmt32);
    return fmt32 ? 3'd4 : 3'd3;
  endfunction

  // memory words a load must fetch for n entries
  function automatic logic [15:0] words_needed(input logic [15:0] n_entries,
                                               input logic fmt32);
    logic [17:0] nbytes;
    nbytes = 18'(n_entries) * (fmt32 ? 18'd4 : 18'd3);
    return 16'((nbytes + 18'd3) >> 2);
  endfunction

  // raw little-endian bytes to a stored entry
  function automatic logic [31:0] unpack_entry(input logic [31:0] raw,
                                               input logic fmt32);
    return fmt32 ? raw : {8'hFF, raw[23:0]};
  endfunction

endpackage

// File: rtl/clut_mem.sv
module clut_mem #(
  parameter int IDX_W = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic             lk_req,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic [DW-1:0]    lk_data,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic [DW-1:0]    cpu_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] tbl [DEPTH];

  always_ff @(posedge clk) begin
    if (we) tbl[widx] <= wdata;
  end

  // registered converter port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_valid <= 1'b0;
      lk_data  <= '0;
    end else begin
      lk_valid <= lk_req;
      if (lk_req) lk_data <= tbl[lk_idx];
    end
  end

  // combinational CPU port, registered in the register block
  assign cpu_data = tbl[cpu_idx];
endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_fmt32,
  input  logic [IDX_W-1:0] start_size,
  input  logic [AW-1:0]    start_addr,
  output logic             mrd_req,
  output logic [AW-1:0]    mrd_addr,
  input  logic             mrd_gnt,
  input  logic             mrd_rvalid,
  input  logic [DW-1:0]    mrd_rdata,
  output logic             busy,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic             done
);
  localparam int BUF_W  = DW + 16;   // up to two carried bytes plus one word
  localparam int WCNT_W = IDX_W + 2;

  logic              busy_q, fmt_q, outst_q, done_q;
  logic [IDX_W-1:0]  size_q, idx_q;
  logic [AW-1:0]     addr_q;
  logic [WCNT_W-1:0] wleft_q;
  logic [BUF_W-1:0]  pack_q;
  logic [2:0]        cnt_q;

  logic [2:0]        eb, cons, rem, ncnt;
  logic              wr_go, last_wr, fire;
  logic [BUF_W-1:0]  npack;

  always_comb begin
    eb      = entry_bytes(fmt_q);
    wr_go   = busy_q && (cnt_q >= eb);
    last_wr = wr_go && (idx_q == size_q);
    mrd_req = busy_q && !outst_q && (wleft_q != '0) && (cnt_q <= 3'd2);
    fire    = mrd_req && mrd_gnt;
    cons    = wr_go ? eb : 3'd0;
    rem     = cnt_q - cons;
    npack   = pack_q >> {cons, 3'b000};
    ncnt    = rem;
    if (mrd_rvalid && busy_q) begin
      npack = npack | (BUF_W'(mrd_rdata) << {rem, 3'b000});
      ncnt  = rem + 3'd4;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fmt_q   <= 1'b0;
      outst_q <= 1'b0;
      done_q  <= 1'b0;
      size_q  <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      wleft_q <= '0;
      pack_q  <= '0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          fmt_q   <= start_fmt32;
          size_q  <= start_size;
          idx_q   <= '0;
          addr_q  <= {start_addr[AW-1:2], 2'b00};
          wleft_q <= WCNT_W'(words_needed(16'(start_size) + 16'd1, start_fmt32));
          pack_q  <= '0;
          cnt_q   <= '0;
          outst_q <= 1'b0;
        end
      end else begin
        if (fire) begin
          outst_q <= 1'b1;
          addr_q  <= addr_q + AW'(4);
          wleft_q <= wleft_q - WCNT_W'(1);
        end
        if (mrd_rvalid) outst_q <= 1'b0;
        if (wr_go) idx_q <= idx_q + IDX_W'(1);
        if (last_wr) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pack_q <= '0;
          cnt_q  <= '0;
        end else begin
          pack_q <= npack;
          cnt_q  <= ncnt;
        end
      end
    end
  end

  assign mrd_addr = addr_q;
  assign busy     = busy_q;
  assign wr_en    = wr_go;
  assign wr_idx   = idx_q;
  assign wr_data  = unpack_entry(pack_q[DW-1:0], fmt_q);
  assign done     = done_q;
endmodule

// File: rtl/clut_regs.sv
module clut_regs
  import clut_pkg::*;
#(
  parameter int              AW       = 32,
  parameter int              IDX_W    = 8,
  parameter int              DW       = 32,
  parameter int              OFS_W    = 12,
  parameter logic [OFS_W-1:0] TBL_BASE = 12'h400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic             cpu_re,
  input  logic [OFS_W-1:0] cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  output logic             cpu_rvalid,
  output logic             irq,
  input  logic             ld_busy,
  input  logic [DW-1:0]    tbl_rdata,
  output logic             ld_start,
  output logic             cfg_fmt32,
  output logic [IDX_W-1:0] cfg_size,
  output logic [AW-1:0]    cfg_addr,
  output logic             tbl_we,
  output logic [IDX_W-1:0] tbl_idx,
  output logic             tbl_conflict,
  output logic             err_flag,
  output logic             err_ie
);
  localparam int TAG_W = OFS_W - IDX_W - 2;
  localparam logic [TAG_W-1:0] TBL_TAG = TBL_BASE[OFS_W-1:IDX_W+2];
  localparam logic [OFS_W-1:0] O_CTRL = OFS_W'(CTRL_OFS);
  localparam logic [OFS_W-1:0] O_ADDR = OFS_W'(ADDR_OFS);
  localparam logic [OFS_W-1:0] O_STAT = OFS_W'(STAT_OFS);

  logic tbl_hit, ctrl_wr, addr_wr, stat_wr, err_q, ie_q, fmt_q;
  logic [IDX_W-1:0] size_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    rd_mux, ctrl_view;

  always_comb begin
    tbl_hit      = (cpu_addr[OFS_W-1:IDX_W+2] == TBL_TAG) && (cpu_addr[1:0] == 2'b00);
    ctrl_wr      = cpu_we && (cpu_addr == O_CTRL) && !ld_busy;
    addr_wr      = cpu_we && (cpu_addr == O_ADDR) && !ld_busy;
    stat_wr      = cpu_we && (cpu_addr == O_STAT);
    ld_start     = ctrl_wr && cpu_wdata[0];
    tbl_conflict = (cpu_we || cpu_re) && tbl_hit && ld_busy;
    tbl_we       = cpu_we && tbl_hit && !ld_busy;
    tbl_idx      = cpu_addr[IDX_W+1:2];
    ctrl_view          = '0;
    ctrl_view[0]       = ld_busy;
    ctrl_view[1]       = fmt_q;
    ctrl_view[8 +: IDX_W] = size_q;
    ctrl_view[16]      = ie_q;
    rd_mux = '0;
    if (tbl_hit)                 rd_mux = ld_busy ? '0 : tbl_rdata;
    else if (cpu_addr == O_CTRL) rd_mux = ctrl_view;
    else if (cpu_addr == O_ADDR) rd_mux = DW'(addr_q);
    else if (cpu_addr == O_STAT) rd_mux = DW'(err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q      <= 1'b0;
      ie_q       <= 1'b0;
      fmt_q      <= 1'b0;
      size_q     <= '0;
      addr_q     <= '0;
      cpu_rdata  <= '0;
      cpu_rvalid <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        fmt_q  <= cpu_wdata[1];
        size_q <= cpu_wdata[8 +: IDX_W];
        ie_q   <= cpu_wdata[16];
      end
      if (addr_wr) addr_q <= AW'(cpu_wdata);
      if (tbl_conflict)                 err_q <= 1'b1;
      else if (stat_wr && cpu_wdata[0]) err_q <= 1'b0;
      cpu_rvalid <= cpu_re;
      if (cpu_re) cpu_rdata <= rd_mux;
    end
  end

  assign cfg_fmt32 = cpu_wdata[1];
  assign cfg_size  = ld_start ? cpu_wdata[8 +: IDX_W] : size_q;
  assign cfg_addr  = addr_q;
  assign err_flag  = err_q;
  assign err_ie    = ie_q;
  assign irq       = err_q && ie_q;
endmodule

// File: rtl/clut_ctrl.sv
module clut_ctrl #(
  parameter int               AW       = 32,
  parameter int               IDX_W    = 8,
  parameter int               DW       = 32,
  parameter int               OFS_W    = 12,
  parameter logic [OFS_W-1:0] TBL_BASE = 12'h400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic             cpu_re,
  input  logic [OFS_W-1:0] cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  output logic             cpu_rvalid,
  output logic             irq,
  input  logic             lk_req,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [DW-1:0]    lk_data,
  output logic             lk_valid,
  output logic             mrd_req,
  output logic [AW-1:0]    mrd_addr,
  input  logic             mrd_gnt,
  input  logic             mrd_rvalid,
  input  logic [DW-1:0]    mrd_rdata,
  output logic             load_done
);
  // named internal events, observed by the bound checker
  logic             ld_busy, ld_start, ld_wr_en;
  logic [IDX_W-1:0] ld_wr_idx;
  logic [DW-1:0]    ld_wr_data;
  logic             cfg_fmt32;
  logic [IDX_W-1:0] cfg_size;
  logic [AW-1:0]    cfg_addr;
  logic             tbl_we, tbl_conflict, err_flag, err_ie;
  logic [IDX_W-1:0] tbl_idx;
  logic [DW-1:0]    tbl_rdata;
  logic             mem_we;
  logic [IDX_W-1:0] mem_widx;
  logic [DW-1:0]    mem_wdata;

  clut_regs #(.AW(AW), .IDX_W(IDX_W), .DW(DW), .OFS_W(OFS_W), .TBL_BASE(TBL_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .irq(irq),
    .ld_busy(ld_busy), .tbl_rdata(tbl_rdata),
    .ld_start(ld_start), .cfg_fmt32(cfg_fmt32), .cfg_size(cfg_size), .cfg_addr(cfg_addr),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_conflict(tbl_conflict),
    .err_flag(err_flag), .err_ie(err_ie)
  );

  clut_loader #(.AW(AW), .IDX_W(IDX_W), .DW(DW)) u_loader (
    .clk(clk), .rst_n(rst_n),
    .start(ld_start), .start_fmt32(cfg_fmt32), .start_size(cfg_size), .start_addr(cfg_addr),
    .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt),
    .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
    .busy(ld_busy), .wr_en(ld_wr_en), .wr_idx(ld_wr_idx), .wr_data(ld_wr_data),
    .done(load_done)
  );

  // the CPU write port is closed while the loader runs, so the two never meet
  assign mem_we    = ld_wr_en || tbl_we;
  assign mem_widx  = ld_wr_en ? ld_wr_idx  : tbl_idx;
  assign mem_wdata = ld_wr_en ? ld_wr_data : cpu_wdata;

  clut_mem #(.IDX_W(IDX_W), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we), .widx(mem_widx), .wdata(mem_wdata),
    .lk_req(lk_req), .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_data(lk_data),
    .cpu_idx(tbl_idx), .cpu_data(tbl_rdata)
  );
endmodule

// File: rtl/clut_ctrl_chk.sv
module clut_ctrl_chk #(
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic             lk_valid,
  input logic             mrd_req,
  input logic             mrd_gnt,
  input logic [AW-1:0]    mrd_addr,
  input logic             ld_wr_en,
  input logic [IDX_W-1:0] ld_wr_idx,
  input logic [IDX_W-1:0] cfg_size,
  input logic             load_done,
  input logic             ld_busy,
  input logic             tbl_we,
  input logic             tbl_conflict,
  input logic             err_flag,
  input logic             err_ie,
  input logic             irq
);
  p_lookup_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_valid);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req && !mrd_gnt) |=> (mrd_req && $stable(mrd_addr)));

  p_one_flight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req && mrd_gnt) |=> !mrd_req);

  p_wr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr_en |-> (ld_wr_idx <= cfg_size));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !ld_busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  p_cpu_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy |-> !tbl_we);

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_conflict |=> err_flag);

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> err_ie);

  p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy |=> (!ld_busy || $stable(cfg_size)));
endmodule

bind clut_ctrl clut_ctrl_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_valid(lk_valid),
  .mrd_req(mrd_req), .mrd_gnt(mrd_gnt), .mrd_addr(mrd_addr),
  .ld_wr_en(ld_wr_en), .ld_wr_idx(ld_wr_idx), .cfg_size(cfg_size),
  .load_done(load_done), .ld_busy(ld_busy), .tbl_we(tbl_we),
  .tbl_conflict(tbl_conflict), .err_flag(err_flag), .err_ie(err_ie), .irq(irq)
);

// File: tb/clut_ctrl_tb.sv
module clut_ctrl_tb;
  localparam int CLK_P = 10;
  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_ADDR = 12'h004;
  localparam logic [11:0] A_STAT = 12'h008;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_we = 0, cpu_re = 0;
  logic [11:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata, lk_data, mrd_addr, mrd_rdata = '0;
  logic cpu_rvalid, irq, lk_valid, mrd_req, load_done;
  logic lk_req = 0, mrd_gnt = 0, mrd_rvalid = 0;
  logic [7:0] lk_idx = '0;

  int checks = 0, errors = 0, done_cnt = 0;
  int grants = 0, addr_bad = 0, resp_slow = 3;
  logic [31:0] salt = '0, exp_addr = '0, paddr = '0;
  logic g_q = 0, pend = 0;
  int rcnt = 0;

  always #(CLK_P/2) clk = ~clk;

  clut_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .irq(irq),
    .lk_req(lk_req), .lk_idx(lk_idx), .lk_data(lk_data), .lk_valid(lk_valid),
    .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt),
    .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata), .load_done(load_done)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ salt ^ 32'h3C6EF372;
  endfunction

  function automatic logic [31:0] exp_entry(input logic [31:0] base, input int i, input bit fmt);
    logic [31:0] e, w;
    if (fmt) return mem_word(base + 32'(4 * i));
    e = 32'hFF00_0000;
    for (int b = 0; b < 3; b++) begin
      int k = 3 * i + b;
      w = mem_word(base + 32'(4 * (k / 4)));
      e[8*b +: 8] = w[8*(k % 4) +: 8];
    end
    return e;
  endfunction

  function automatic int exp_words(input int n, input bit fmt);
    return (n * (fmt ? 4 : 3) + 3) / 4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder: random grant delay, data one or more cycles later
  always @(negedge clk) begin
    if (load_done) done_cnt++;
    mrd_gnt = 1'b0;
    mrd_rvalid = 1'b0;
    if (g_q) begin pend = 1'b1; g_q = 1'b0; end
    if (pend) begin
      if (rcnt == 0) begin
        mrd_rvalid = 1'b1;
        mrd_rdata = mem_word(paddr);
        pend = 1'b0;
      end else rcnt--;
    end else if (mrd_req && ($urandom % 4 != 0)) begin
      mrd_gnt = 1'b1;
      g_q = 1'b1;
      paddr = mrd_addr;
      rcnt = int'($urandom % resp_slow);
      if (mrd_addr !== exp_addr) addr_bad++;
      exp_addr = exp_addr + 32'd4;
      grants++;
    end
  end

  task automatic cpu_write(input logic [11:0] a, input logic [31:0] d);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [11:0] a, output logic [31:0] d, output logic v);
    cpu_re = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_re = 1'b0;
    d = cpu_rdata; v = cpu_rvalid;
  endtask

  task automatic lookup(input logic [7:0] i, output logic [31:0] d, output logic v);
    lk_req = 1'b1; lk_idx = i;
    @(negedge clk);
    lk_req = 1'b0;
    d = lk_data; v = lk_valid;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic verify_table(input logic [31:0] base, input int size, input bit fmt);
    logic [31:0] d; logic v;
    for (int i = 0; i <= size; i++) begin
      if ($urandom % 2 == 0) begin
        lookup(8'(i), d, v);
        chk("R3 lookup valid", 32'(v), 32'd1);
      end else
        cpu_read(12'h400 + 12'(4 * i), d, v);
      chk(fmt ? "R5 entry" : "R6 entry", d, exp_entry(base, i, fmt));
    end
  endtask

  task automatic run_load(input logic [31:0] base, input int size, input bit fmt);
    int d0;
    logic [31:0] d; logic v;
    salt = $urandom;
    cpu_write(A_ADDR, base);
    exp_addr = base; grants = 0; addr_bad = 0;
    d0 = done_cnt;
    cpu_write(A_CTRL, {15'b0, 1'b0, 8'(size), 6'b0, fmt, 1'b1});
    wait_done(d0);
    repeat (3) @(negedge clk);
    chk("R8 single done pulse", 32'(done_cnt - d0), 32'd1);
    cpu_read(A_CTRL, d, v);
    chk("R8 start bit cleared", 32'(d[0]), 32'd0);
    chk("R4 size field", 32'(d[15:8]), 32'(size));
    chk("R7 word count", 32'(grants), 32'(exp_words(size + 1, fmt)));
    chk("R7 address order", 32'(addr_bad), 32'd0);
    verify_table(base, size, fmt);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, k200;
    logic v;
    int d0;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cpu_read(A_CTRL, d, v); chk("R1 ctrl", d, 32'd0);
    cpu_read(A_ADDR, d, v); chk("R1 addr", d, 32'd0);
    cpu_read(A_STAT, d, v); chk("R1 status", d, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 mrd_req", 32'(mrd_req), 32'd0);

    // R2 / R3 manual table access
    for (int n = 0; n < 12; n++) begin
      logic [7:0] i; logic [31:0] w;
      i = 8'($urandom); w = $urandom;
      if (n == 0) i = 8'd0;
      if (n == 1) i = 8'hFF;
      cpu_write(12'h400 + {2'b00, i, 2'b00}, w);
      cpu_read(12'h400 + {2'b00, i, 2'b00}, d, v);
      chk("R2 read valid", 32'(v), 32'd1);
      chk("R2 readback", d, w);
      lookup(i, d, v);
      chk("R3 lookup valid", 32'(v), 32'd1);
      chk("R3 lookup data", d, w);
    end

    // directed corner loads: R4 R5 R6 R7 R8
    run_load(32'h0000_1000, 0, 1'b1);
    run_load(32'h0000_2000, 0, 1'b0);
    run_load(32'h0001_0000, 255, 1'b1);
    run_load(32'h0002_0000, 255, 1'b0);
    run_load(32'h0003_0000, 4, 1'b0);

    // random loads
    for (int n = 0; n < 6; n++) begin
      resp_slow = 1 + int'($urandom % 4);
      run_load({$urandom} & 32'hFFFF_FFFC, int'($urandom % 256), 1'($urandom));
    end

    // conflict handling: R9 R10 R11 R12
    resp_slow = 10;
    k200 = 32'hCAFE_0200;
    cpu_write(12'h400 + 12'(4 * 200), k200);
    salt = $urandom;
    cpu_write(A_ADDR, 32'h0004_0000);
    exp_addr = 32'h0004_0000; grants = 0;
    d0 = done_cnt;
    cpu_write(A_CTRL, {15'b0, 1'b1, 8'd20, 6'b0, 1'b1, 1'b1});
    cpu_read(A_CTRL, d, v);
    chk("R4 start bit busy", 32'(d[0]), 32'd1);
    cpu_write(12'h400 + 12'(4 * 200), 32'h1111_2222);
    cpu_read(12'h400 + 12'(4 * 200), d, v);
    chk("R9 blocked read valid", 32'(v), 32'd1);
    chk("R9 blocked read zero", d, 32'd0);
    cpu_read(A_STAT, d, v);
    chk("R10 flag set", d, 32'd1);
    chk("R11 irq enabled", 32'(irq), 32'd1);
    cpu_write(A_CTRL, {15'b0, 1'b0, 8'd99, 6'b0, 1'b0, 1'b0});
    cpu_write(A_ADDR, 32'h0BAD_0000);
    wait_done(d0);
    @(negedge clk);
    cpu_read(A_CTRL, d, v);
    chk("R12 ctrl unchanged", d, {15'b0, 1'b1, 8'd20, 6'b0, 1'b1, 1'b0});
    cpu_read(A_ADDR, d, v);
    chk("R12 addr unchanged", d, 32'h0004_0000);
    cpu_read(12'h400 + 12'(4 * 200), d, v);
    chk("R9 write dropped", d, k200);
    verify_table(32'h0004_0000, 20, 1'b1);
    cpu_read(A_STAT, d, v);
    chk("R10 flag sticky", d, 32'd1);
    cpu_write(A_STAT, 32'd1);
    cpu_read(A_STAT, d, v);
    chk("R10 flag cleared", d, 32'd0);
    chk("R11 irq low after clear", 32'(irq), 32'd0);

    // R11 gating with enable off
    salt = $urandom;
    cpu_write(A_ADDR, 32'h0005_0000);
    exp_addr = 32'h0005_0000;
    d0 = done_cnt;
    cpu_write(A_CTRL, {15'b0, 1'b0, 8'd20, 6'b0, 1'b0, 1'b1});
    cpu_read(12'h400, d, v);
    cpu_read(A_STAT, d, v);
    chk("R10 flag set on read conflict", d, 32'd1);
    chk("R11 irq gated off", 32'(irq), 32'd0);
    wait_done(d0);
    @(negedge clk);
    cpu_write(A_CTRL, {15'b0, 1'b1, 8'd20, 6'b0, 1'b0, 1'b0});
    @(negedge clk);
    chk("R11 irq when enabled later", 32'(irq), 32'd1);
    cpu_write(A_STAT, 32'd1);
    chk("R11 irq after clear", 32'(irq), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule